// File: doc/BRIEF.md
# Dual-Group Programmable Logic Array

This block is a small field-configurable logic fabric made of sixteen cells in two groups of eight. Each cell evaluates any two-input boolean function through a four-entry truth table. It can present the result directly or through a private flip-flop. Each cell has one dedicated input pin and one dedicated output pin. Its two operands are chosen by per-cell selectors from:

- a software-written data bit,
- the cell's own pin,
- the registered outputs of related cells,
- constants.

The two groups are joined by one fixed cross-link in each direction. The first cell of each group can pick up the last cell of the other group.

Software sets each cell through one configuration register, placed at a word-spaced offset. A data-in register supplies one bit per cell. A read-only data-out register returns all cell outputs. The register bus is a plain synchronous port. Read data is registered and appears one cycle after the address is presented.

Top module: `lga_array`

## Requirements
- R1: A synchronous active-high reset clears every configuration register and the data-in register. After reset, every mapped register reads 0 and every output pin is 0.
- R2: The configuration register for cell n is read/write at byte offset 4*n (0x00 to 0x3C). It holds bits [10:0] only. Writes to bits [31:11] are ignored, and reads return those bits as 0.
- R3: The data-in register at offset 0x40 holds 16 bits, and bit n is the software bit of cell n. Writes to bits [31:16] are ignored.
- R4: The register at offset 0x44 is read-only and returns the output of cell n in bit n. A write to it changes no register.
- R5: Reads return data on `bus_rdata` in the cycle after the address is presented. A read returns 0 for any offset not named above, and for any address whose two low bits are not zero.
- R6: Bits [4:1] hold a truth table T. The cell's function result is T[{A,B}], with A as the upper index bit.
- R7: Operand A comes from selector 0 when bit 6 is 1, and from the cell's data-in bit when bit 6 is 0. Operand B comes from the cell's input pin when bit 5 is 1, and from selector 1 when bit 5 is 0.
- R8: Selector 0 is chosen by bits [10:9]:
  - 0 picks the link source. This is the previous cell in the same group, except that cell 0 takes cell 15 and cell 8 takes cell 7.
  - 1 picks the cell itself.
  - 2 picks the next cell in the group, with cell 7 wrapping to cell 0 and cell 15 wrapping to cell 8.
  - 3 gives a constant 0.
- R9: Selector 1 is chosen by bits [8:7]:
  - 0 picks the next cell in the group, with the same wrap as R8.
  - 1 picks the cell itself.
  - 2 picks the cell at the same position in the other group (n XOR 8).
  - 3 gives a constant 1.
- R10: When bit 0 is 1, the cell output is the function result in the same cycle. When bit 0 is 0, the output is the result captured at the previous clock edge. Every cell-to-cell source in R8 and R9 takes the other cell's flip-flop value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the address |
| pin_in | input | 16 | Dedicated input pin of each cell |
| pin_out | output | 16 | Dedicated output pin of each cell |

## Verification
The bench builds the block with its default group size of eight and an 8-bit address. With these values, the cross-links resolve to cells 15→0 and 7→8, the wraps resolve to 7→0 and 15→8, and the peer of cell 9 is cell 1. The data registers land at 0x40 and 0x44, so 0x48, 0xFC and a misaligned address can all be probed as unmapped. One cell is swept through all sixteen truth tables against all four operand pairs. Further cells exercise the flip-flop delay, a self-toggling loop, and every selector source.

// File: rtl/lga_pkg.sv
package lga_pkg;

    // Per-cell configuration, packed in register bit order (bit 10 down to bit 0)
    typedef struct packed {
        logic [1:0] a_src;     // selector 0 choice
        logic [1:0] b_src;     // selector 1 choice
        logic       a_use_sel; // 1: A from selector 0, 0: A from data-in bit
        logic       b_use_pin; // 1: B from pin, 0: B from selector 1
        logic [3:0] table_bits;
        logic       bypass;    // 1: combinational output
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic eval_table(input logic [3:0] tbl, input logic a, input logic b);
        return tbl[{a, b}];
    endfunction

endpackage

// File: rtl/lga_cell.sv
module lga_cell
    import lga_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cfg_t cfg_i,
    input  logic      pin_i,
    input  logic      din_i,
    input  logic [3:0] sel0_src_i,
    input  logic [3:0] sel1_src_i,
    output logic      q_o,
    output logic      out_o
);

    logic op_a;
    logic op_b;
    logic func;
    logic q;

    always_comb begin
        op_a = cfg_i.a_use_sel ? sel0_src_i[cfg_i.a_src] : din_i;
        op_b = cfg_i.b_use_pin ? pin_i : sel1_src_i[cfg_i.b_src];
        func = eval_table(cfg_i.table_bits, op_a, op_b);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= func;
    end

    assign q_o   = q;
    assign out_o = cfg_i.bypass ? func : q;

    // R10: a registered cell shows the result captured one edge earlier
    assert_ff_delay_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cfg_i.bypass || out_o == $past(func)));

    // R6: constant tables force the bypassed output
    assert_table_one_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.bypass && cfg_i.table_bits == 4'hF) |-> out_o);
    assert_table_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.bypass && cfg_i.table_bits == 4'h0) |-> !out_o);

endmodule

// File: rtl/lga_regs.sv
module lga_regs
    import lga_pkg::*;
#(
    parameter int NCELL  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCELL-1:0]  cell_out_i,
    output cell_cfg_t         cfg_o [NCELL],
    output logic [NCELL-1:0]  din_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] DIN_IDX  = IDX_W'(NCELL);
    localparam logic [IDX_W-1:0] DOUT_IDX = IDX_W'(NCELL + 1);

    logic [IDX_W-1:0]  word_idx;
    logic              aligned;
    logic              hit;
    logic [DATA_W-1:0] rd_next;
    cell_cfg_t         cfg_q [NCELL];
    logic [NCELL-1:0]  din_q;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NCELL; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= '0;
            else if (bus_we && aligned && word_idx == IDX_W'(i))
                cfg_q[i] <= cell_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
        assign cfg_o[i] = cfg_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            din_q <= '0;
        else if (bus_we && aligned && word_idx == DIN_IDX)
            din_q <= bus_wdata[NCELL-1:0];
    end
    assign din_o = din_q;

    always_comb begin
        rd_next = '0;
        hit     = 1'b0;
        if (aligned) begin
            for (int i = 0; i < NCELL; i++) begin
                if (word_idx == IDX_W'(i)) begin
                    rd_next = {{(DATA_W-CFG_W){1'b0}}, cfg_q[i]};
                    hit     = 1'b1;
                end
            end
            if (word_idx == DIN_IDX) begin
                rd_next = {{(DATA_W-NCELL){1'b0}}, din_q};
                hit     = 1'b1;
            end
            if (word_idx == DOUT_IDX) begin
                rd_next = {{(DATA_W-NCELL){1'b0}}, cell_out_i};
                hit     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

    // R1: reset leaves data-in and cell 0 configuration cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (din_q == '0 && cfg_q[0] == '0));

    // R5: an unmapped or misaligned address reads zero next cycle
    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !hit |=> bus_rdata == '0);

    // R4: writing the read-only output register disturbs nothing
    assert_dout_readonly_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && aligned && word_idx == DOUT_IDX) |=> ($stable(din_q) && $stable(cfg_q[0])));

    // R3: data-in write captures the low bits of write data
    assert_din_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && aligned && word_idx == DIN_IDX) |=> din_q == $past(bus_wdata[NCELL-1:0]));

endmodule

// File: rtl/lga_array.sv
module lga_array
    import lga_pkg::*;
#(
    parameter int GROUP_SIZE = 8,
    parameter int ADDR_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [2*GROUP_SIZE-1:0]   pin_in,
    output logic [2*GROUP_SIZE-1:0]   pin_out
);

    localparam int NCELL = 2 * GROUP_SIZE;

    cell_cfg_t        cfg [NCELL];
    logic [NCELL-1:0] din;
    logic [NCELL-1:0] q_vec;
    logic [NCELL-1:0] out_vec;

    lga_regs #(
        .NCELL (NCELL),
        .ADDR_W(ADDR_W),
        .DATA_W(32)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cell_out_i(out_vec),
        .cfg_o     (cfg),
        .din_o     (din)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        localparam int GRP  = i / GROUP_SIZE;
        localparam int POS  = i % GROUP_SIZE;
        localparam int LINK = (POS == 0) ? ((1 - GRP) * GROUP_SIZE + GROUP_SIZE - 1) : (i - 1);
        localparam int NEXT = GRP * GROUP_SIZE + (POS + 1) % GROUP_SIZE;
        localparam int PEER = (i + GROUP_SIZE) % NCELL;

        logic [3:0] sel0_src;
        logic [3:0] sel1_src;
        assign sel0_src = {1'b0, q_vec[NEXT], q_vec[i], q_vec[LINK]};
        assign sel1_src = {1'b1, q_vec[PEER], q_vec[i], q_vec[NEXT]};

        lga_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .cfg_i     (cfg[i]),
            .pin_i     (pin_in[i]),
            .din_i     (din[i]),
            .sel0_src_i(sel0_src),
            .sel1_src_i(sel1_src),
            .q_o       (q_vec[i]),
            .out_o     (out_vec[i])
        );
    end

    assign pin_out = out_vec;

    // R8: cell 0 in pass-through of its link shows the registered value of the last cell
    assert_xlink_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg[0].a_src == 2'd0 && cfg[0].a_use_sel && cfg[0].table_bits == 4'b1100 && cfg[0].bypass)
        |-> pin_out[0] == q_vec[NCELL-1]);

endmodule

// File: tb/test_lga_array.sv
module test_lga_array;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    lga_array i_lga_array (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] cfgv(int s0, int s1, int a_sel, int b_pin, int tbl, int byp);
        return (32'(s0) << 9) | (32'(s1) << 7) | (32'(a_sel) << 6) | (32'(b_pin) << 5)
             | (32'(tbl) << 1) | 32'(byp);
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        exp_q.push_back(exp); due_q.push_back(cyc + 1); tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin_in = '0;
        idle(2);
        rst = 1'b0;
    endtask

    // monitor: pops expected read data in the cycle it becomes valid
    always @(posedge clk) begin
        #2;
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            void'(due_q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int i = 0; i < 16; i++) rd(8'(4*i), 32'h0, "R1 cfg after reset");
        rd(8'h40, 32'h0, "R1 din after reset");
        rd(8'h44, 32'h0, "R1 dout after reset");
        @(negedge clk); chk(32'(pin_out), 32'h0, "R1 pins after reset");

        // R2: reserved bits dropped; R3: upper din bits dropped
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0000_07FF, "R2 cfg3 readback");
        wr(8'h3C, 32'h1234_5555);
        rd(8'h3C, 32'h0000_0555, "R2 cfg15 readback");
        wr(8'h3C, 32'h0);
        wr(8'h40, 32'hFFFF_ABCD);
        rd(8'h40, 32'h0000_ABCD, "R3 din readback");
        wr(8'h40, 32'h0);
        // R5: unmapped and misaligned
        rd(8'h48, 32'h0, "R5 unmapped 0x48");
        rd(8'hFC, 32'h0, "R5 unmapped 0xFC");
        rd(8'h0D, 32'h0, "R5 misaligned 0x0D");
        // R4: cell3 = const 1 bypassed; write to dout ignored
        rd(8'h44, 32'h0000_0008, "R4 dout bit3");
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, 32'h0000_0008, "R4 dout after write");
        rd(8'h0C, 32'h0000_07FF, "R4 cfg3 unchanged");
        rd(8'h40, 32'h0, "R4 din unchanged");
        idle(2);

        // R6/R7: cell 5, A from din bit5, B from pin5, bypassed
        do_reset();
        for (int t = 0; t < 16; t++) begin
            wr(8'h14, cfgv(0, 0, 0, 1, t, 1));
            for (int ab = 0; ab < 4; ab++) begin
                pin_in[5] = ab[0];
                wr(8'h40, 32'(ab[1]) << 5);
                chk(32'(pin_out[5]), 32'(t[ab]), $sformatf("R6 R7 table=%0d ab=%0d", t, ab));
            end
        end

        // R10: registered path delays one cycle
        do_reset();
        wr(8'h08, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h40, 32'h4);
        chk(32'(pin_out[2]), 32'h0, "R10 before edge");
        idle(1);
        chk(32'(pin_out[2]), 32'h1, "R10 after edge");

        // R8 own: toggle loop on cell 4 (A=self, B=pin, XOR, registered)
        do_reset();
        pin_in[4] = 1'b1;
        wr(8'h10, cfgv(1, 0, 1, 1, 4'b0110, 0));
        chk(32'(pin_out[4]), 32'h0, "R8 own toggle 0");
        idle(1);
        chk(32'(pin_out[4]), 32'h1, "R8 own toggle 1");
        idle(1);
        chk(32'(pin_out[4]), 32'h0, "R8 own toggle 2");

        // R8 cross-links 15->0 and 7->8
        do_reset();
        wr(8'h3C, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h1C, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h00, cfgv(0, 0, 1, 0, 4'b1100, 1));
        wr(8'h20, cfgv(0, 0, 1, 0, 4'b1100, 1));
        wr(8'h40, 32'h8080);
        chk(32'(pin_out[0]), 32'h0, "R8 link 15->0 before");
        chk(32'(pin_out[8]), 32'h0, "R8 link 7->8 before");
        idle(1);
        chk(32'(pin_out[0]), 32'h1, "R8 link 15->0 after");
        chk(32'(pin_out[8]), 32'h1, "R8 link 7->8 after");

        // R8 next wrap, zero; R9 peer, next wrap, one
        do_reset();
        wr(8'h00, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h04, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h20, cfgv(0, 0, 0, 0, 4'b1100, 0));
        wr(8'h1C, cfgv(2, 0, 1, 0, 4'b1100, 1));
        wr(8'h24, cfgv(0, 2, 0, 0, 4'b1010, 1));
        wr(8'h3C, cfgv(0, 0, 0, 0, 4'b1010, 1));
        wr(8'h30, cfgv(3, 0, 1, 0, 4'b0011, 1));
        wr(8'h34, cfgv(0, 3, 0, 0, 4'b1010, 1));
        chk(32'(pin_out[12]), 32'h1, "R8 sel0 const zero");
        chk(32'(pin_out[13]), 32'h1, "R9 sel1 const one");
        wr(8'h40, 32'h0103);
        chk(32'(pin_out[7]), 32'h0, "R8 next wrap before");
        chk(32'(pin_out[9]), 32'h0, "R9 peer before");
        idle(1);
        chk(32'(pin_out[7]), 32'h1, "R8 next wrap 0->7");
        chk(32'(pin_out[9]), 32'h1, "R9 peer 1->9");
        chk(32'(pin_out[15]), 32'h1, "R9 next wrap 8->15");
        rd(8'h44, 32'h0000_B383, "R4 dout pattern");
        idle(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule